// File: doc/BRIEF.md
# Parallel Converter Host Interface Controller

This block is the digital front end of an 8-bit analog-to-digital converter that sits on a parallel processor bus. A host drives three active-low strobes (chip select, read, write) and a mode pin. The block turns these into single-cycle start requests for a conversion core and accepts that core's results. Back to the host it presents a result register on an 8-bit data bus, an active-low interrupt and a ready/busy flag. The data bus is brought out as data plus an output-enable so the pad ring can build the three-state buffer. An optional channel-address input picks one of two analog inputs. The address takes effect one conversion late: the address captured at a start selects the input for the following conversion.

The mode pin selects one of two ways to start a conversion. With the pin low, a read strobe both starts a conversion and reads the result. If the read is held, the new result appears on the bus when the conversion ends. If the read is short, it returns the previous result, which gives pipelined operation. With the pin high, a write strobe starts the conversion. A later read collects the result, and a read issued before the conversion finishes forces the interrupt low at once. Chip select and read may also be tied low, so that write pulses alone pace the converter and the bus follows each new result.

Every strobe and the mode and address pins pass through a two-flop synchroniser before edge detection. The conversion core is modelled as a start pulse answered some cycles later by a one-cycle done pulse that carries the data.

Top module: `adc_host_if`

## Requirements
- R1: Each host input is synchronised by two flip-flops before edge detection. A start strobe whose falling edge is set up before clock edge 1 produces a `conv_start` pulse that is high between edges 3 and 4. The pulse is exactly one cycle wide.
- R2: With `mode` low (0), a falling `rd_n` while `cs_n` is low starts one conversion. A falling `rd_n` while `cs_n` is high starts none.
- R3: A start request that arrives while a conversion is in progress is ignored. It produces no `conv_start`, and its channel address is not captured.
- R4: `db_oe` is 1 exactly when the synchronised `cs_n` and `rd_n` are both low. `db_out` shows the result register, with bit 0 the LSB and bit 7 the MSB. That register loads `conv_data` at each done pulse, so a read held through the end of a conversion shows the new result.
- R5: `int_n` goes low in the cycle after a done pulse. It returns high on the next synchronised rising edge of `rd_n` or at the next conversion start, whichever comes first.
- R6: `rdy` goes low after `cs_n` falls or when a conversion starts. It goes high after the done pulse. If `cs_n` rises with no conversion in progress, `rdy` returns high.
- R7: A short read pulse in read-start mode starts a conversion and returns the previous result. After reset the first read returns 0x00 (the reset value of the result register). The second returns a result converted on the reset-default channel. The third is the first whose channel was chosen by the host.
- R8: With `mode` high (1), a falling `wr_n` while `cs_n` is low starts a conversion. A read strobe alone starts none.
- R9: In write-start mode, a read with `cs_n` low that falls during a conversion drives `int_n` low at once and enables the bus. That conversion's later done pulse does not raise a second interrupt.
- R10: With `mode` 1 and `cs_n` and `rd_n` held low, write pulses alone start conversions. `db_out` updates after each one with `db_oe` held at 1.
- R11: `chan_addr` is captured at each accepted start. `conv_chan` for a conversion equals the address captured at the previous accepted start, and 0 for the first conversion after reset.
- R12: After reset, `conv_start` = 0, `int_n` = 1, `rdy` = 1, `db_oe` = 0 and `db_out` = 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Host chip select, active low, asynchronous |
| rd_n | input | 1 | Host read strobe, active low, asynchronous |
| wr_n | input | 1 | Host write strobe, active low, asynchronous |
| mode | input | 1 | 0 = read starts conversion, 1 = write starts conversion |
| chan_addr | input | CHW | Channel address sampled at each accepted start |
| conv_start | output | 1 | One-cycle start request to the conversion core |
| conv_chan | output | CHW | Input channel for the conversion being started |
| conv_done | input | 1 | One-cycle completion pulse from the core |
| conv_data | input | DW | Conversion result, valid with `conv_done` |
| db_out | output | DW | Result register toward the bus pads |
| db_oe | output | 1 | Bus pad drive enable (0 = high impedance) |
| int_n | output | 1 | Active-low end-of-conversion interrupt |
| rdy | output | 1 | High when ready, low while selected or converting |

## Verification
The bench drives each start style with its own strobe pattern:
- a read held across the whole conversion;
- a read pulse far shorter than the conversion;
- a write followed by a late read;
- a write followed by an early read, both held and released;
- write pulses alone with select and read tied low.

Separating the held read from the short read tells live result capture apart from pipelined return of the previous result. Separating the early read from the late read shows whether the forced interrupt suppresses the one at done.

An eight-step sweep of channel addresses, together with a core model that returns the channel it was handed inside the data, shows whether the one-conversion channel lag is kept. The same sweep tells apart an address captured at the start from one taken at done or ignored entirely. Strobes issued with select high or during a busy conversion check that no start is counted and no address is absorbed.

// File: rtl/adc_host_if_pkg.sv
package adc_host_if_pkg;

  // Which host strobe launches a conversion (selected by the mode pin).
  typedef enum logic {
    MODE_RD_START = 1'b0,
    MODE_WR_START = 1'b1
  } start_mode_e;

  // Bit positions inside the synchronised host-input vector.
  localparam int HI_CS   = 0;
  localparam int HI_RD   = 1;
  localparam int HI_WR   = 2;
  localparam int HI_MODE = 3;
  localparam int HI_ADDR = 4;

endpackage

// File: rtl/adc_sync_chain.sv
// Multi-stage synchroniser for a vector of asynchronous host pins.
module adc_sync_chain #(
  parameter int            W       = 5,
  parameter int            STAGES  = 2,
  parameter logic [W-1:0]  RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [STAGES-1:0][W-1:0] pipe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe_q <= {STAGES{RST_VAL}};
    end else begin
      pipe_q[0] <= din;
      for (int i = 1; i < STAGES; i++) begin
        pipe_q[i] <= pipe_q[i-1];
      end
    end
  end

  assign dout = pipe_q[STAGES-1];

endmodule

// File: rtl/adc_edge_det.sv
// Edge detection on the synchronised strobe levels.
module adc_edge_det (
  input  logic clk,
  input  logic rst,
  input  logic cs_lvl,
  input  logic rd_lvl,
  input  logic wr_lvl,
  output logic cs_fall,
  output logic cs_rise,
  output logic rd_fall,
  output logic rd_rise,
  output logic wr_fall
);

  logic cs_prev, rd_prev, wr_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_prev <= 1'b1;
      rd_prev <= 1'b1;
      wr_prev <= 1'b1;
    end else begin
      cs_prev <= cs_lvl;
      rd_prev <= rd_lvl;
      wr_prev <= wr_lvl;
    end
  end

  assign cs_fall = cs_prev & ~cs_lvl;
  assign cs_rise = ~cs_prev & cs_lvl;
  assign rd_fall = rd_prev & ~rd_lvl;
  assign rd_rise = ~rd_prev & rd_lvl;
  assign wr_fall = wr_prev & ~wr_lvl;

endmodule

// File: rtl/adc_conv_seq.sv
// Start arbitration, busy tracking and delayed channel switching.
module adc_conv_seq
  import adc_host_if_pkg::*;
#(
  parameter int CHW = 1
) (
  input  logic           clk,
  input  logic           rst,
  input  start_mode_e    mode_lvl,
  input  logic           cs_lvl,
  input  logic           rd_fall,
  input  logic           wr_fall,
  input  logic [CHW-1:0] addr_lvl,
  input  logic           conv_done,
  output logic           accept,
  output logic           done_ok,
  output logic           busy,
  output logic           conv_start,
  output logic [CHW-1:0] conv_chan
);

  logic           req;
  logic           busy_q, start_q;
  logic [CHW-1:0] active_q, pend_q, chan_q;

  always_comb begin
    if (mode_lvl == MODE_WR_START) req = wr_fall;
    else                           req = rd_fall;
    req = req & ~cs_lvl;
  end

  assign accept  = req & ~busy_q;
  assign done_ok = conv_done & busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      start_q  <= 1'b0;
      active_q <= '0;
      pend_q   <= '0;
      chan_q   <= '0;
    end else begin
      start_q <= accept;
      if (accept) begin
        busy_q <= 1'b1;
        chan_q <= active_q;   // this conversion uses the previously chosen input
        pend_q <= addr_lvl;   // new choice applies once this one finishes
      end else if (done_ok) begin
        busy_q   <= 1'b0;
        active_q <= pend_q;
      end
    end
  end

  assign busy       = busy_q;
  assign conv_start = start_q;
  assign conv_chan  = chan_q;

endmodule

// File: rtl/adc_out_stage.sv
// Result register, bus enable, interrupt and ready flag.
module adc_out_stage
  import adc_host_if_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  start_mode_e   mode_lvl,
  input  logic          cs_lvl,
  input  logic          rd_lvl,
  input  logic          cs_fall,
  input  logic          cs_rise,
  input  logic          rd_fall,
  input  logic          rd_rise,
  input  logic          accept,
  input  logic          busy,
  input  logic          done_ok,
  input  logic [DW-1:0] conv_data,
  output logic [DW-1:0] db_out,
  output logic          db_oe,
  output logic          int_n,
  output logic          rdy
);

  logic [DW-1:0] res_q;
  logic          oe_q, int_q, rdy_q, early_q;
  logic          early_rd;

  // Read arriving mid-conversion in write-start mode forces the interrupt.
  assign early_rd = (mode_lvl == MODE_WR_START) & rd_fall & ~cs_lvl & busy & ~early_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q   <= '0;
      oe_q    <= 1'b0;
      int_q   <= 1'b1;
      rdy_q   <= 1'b1;
      early_q <= 1'b0;
    end else begin
      oe_q <= ~cs_lvl & ~rd_lvl;
      if (done_ok) res_q <= conv_data;

      if (accept) begin
        int_q   <= 1'b1;
        early_q <= 1'b0;
      end else if (early_rd) begin
        int_q   <= 1'b0;
        early_q <= 1'b1;
      end else if (done_ok && !early_q) begin
        int_q <= 1'b0;
      end else if (rd_rise) begin
        int_q <= 1'b1;
      end

      if (done_ok)                  rdy_q <= 1'b1;
      else if (cs_fall || accept)   rdy_q <= 1'b0;
      else if (cs_rise && !busy)    rdy_q <= 1'b1;
    end
  end

  assign db_out = res_q;
  assign db_oe  = oe_q;
  assign int_n  = int_q;
  assign rdy    = rdy_q;

endmodule

// File: rtl/adc_host_if.sv
module adc_host_if
  import adc_host_if_pkg::*;
#(
  parameter int DW          = 8,
  parameter int CHW         = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cs_n,
  input  logic           rd_n,
  input  logic           wr_n,
  input  logic           mode,
  input  logic [CHW-1:0] chan_addr,
  output logic           conv_start,
  output logic [CHW-1:0] conv_chan,
  input  logic           conv_done,
  input  logic [DW-1:0]  conv_data,
  output logic [DW-1:0]  db_out,
  output logic           db_oe,
  output logic           int_n,
  output logic           rdy
);

  localparam int            SW       = HI_ADDR + CHW;
  localparam logic [SW-1:0] SYNC_RST = {{CHW{1'b0}}, 4'b0111};

  logic [SW-1:0]  raw_in, sync_q;
  logic           cs_lvl, rd_lvl, wr_lvl;
  logic [CHW-1:0] addr_lvl;
  start_mode_e    mode_lvl;
  logic           cs_fall, cs_rise, rd_fall, rd_rise, wr_fall;
  logic           accept, done_ok, busy;

  assign raw_in = {chan_addr, mode, wr_n, rd_n, cs_n};

  adc_sync_chain #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst(rst), .din(raw_in), .dout(sync_q)
  );

  assign cs_lvl   = sync_q[HI_CS];
  assign rd_lvl   = sync_q[HI_RD];
  assign wr_lvl   = sync_q[HI_WR];
  assign mode_lvl = start_mode_e'(sync_q[HI_MODE]);
  assign addr_lvl = sync_q[HI_ADDR +: CHW];

  adc_edge_det u_edge (
    .clk(clk), .rst(rst),
    .cs_lvl(cs_lvl), .rd_lvl(rd_lvl), .wr_lvl(wr_lvl),
    .cs_fall(cs_fall), .cs_rise(cs_rise),
    .rd_fall(rd_fall), .rd_rise(rd_rise), .wr_fall(wr_fall)
  );

  adc_conv_seq #(.CHW(CHW)) u_seq (
    .clk(clk), .rst(rst), .mode_lvl(mode_lvl), .cs_lvl(cs_lvl),
    .rd_fall(rd_fall), .wr_fall(wr_fall), .addr_lvl(addr_lvl),
    .conv_done(conv_done), .accept(accept), .done_ok(done_ok),
    .busy(busy), .conv_start(conv_start), .conv_chan(conv_chan)
  );

  adc_out_stage #(.DW(DW)) u_out (
    .clk(clk), .rst(rst), .mode_lvl(mode_lvl), .cs_lvl(cs_lvl), .rd_lvl(rd_lvl),
    .cs_fall(cs_fall), .cs_rise(cs_rise), .rd_fall(rd_fall), .rd_rise(rd_rise),
    .accept(accept), .busy(busy), .done_ok(done_ok), .conv_data(conv_data),
    .db_out(db_out), .db_oe(db_oe), .int_n(int_n), .rdy(rdy)
  );

endmodule

// File: rtl/adc_host_if_chk.sv
module adc_host_if_chk #(
  parameter int CHW = 1
) (
  input logic           clk,
  input logic           rst,
  input logic           cs_n,
  input logic           rd_n,
  input logic           conv_start,
  input logic           conv_done,
  input logic [CHW-1:0] conv_chan,
  input logic           db_oe,
  input logic           int_n,
  input logic           rdy,
  input logic           busy,
  input logic           mode_lvl
);

  // Cycles since reset release, saturating; gates the look-back check.
  logic [1:0] age_q;
  always_ff @(posedge clk) begin
    if (rst)                 age_q <= 2'd0;
    else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
  end

  p_start_pulse_r1: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> !conv_start);

  p_busy_blocks_r3: assert property (@(posedge clk) disable iff (rst)
    busy |=> !conv_start);

  p_oe_follows_r4: assert property (@(posedge clk) disable iff (rst)
    (age_q == 2'd3) |-> (db_oe == $past(!cs_n && !rd_n, 3)));

  p_int_on_done_r5: assert property (@(posedge clk) disable iff (rst)
    (busy && conv_done && !mode_lvl) |=> !int_n);

  p_int_clear_r5: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> int_n);

  p_rdy_done_r6: assert property (@(posedge clk) disable iff (rst)
    (busy && conv_done) |=> rdy);

  p_rdy_busy_r6: assert property (@(posedge clk) disable iff (rst)
    busy |-> !rdy);

  p_chan_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (busy && !conv_done) |=> $stable(conv_chan));

endmodule

bind adc_host_if adc_host_if_chk #(.CHW(CHW)) u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n),
  .conv_start(conv_start), .conv_done(conv_done), .conv_chan(conv_chan),
  .db_oe(db_oe), .int_n(int_n), .rdy(rdy), .busy(busy), .mode_lvl(mode_lvl)
);

// File: tb/adc_host_if_bench.sv
`timescale 1ns/1ps
module adc_host_if_bench;

  localparam int LAT = 20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, mode = 1'b0;
  logic [0:0] chan_addr = '0;
  logic       conv_start, conv_done;
  logic [0:0] conv_chan;
  logic [7:0] conv_data, db_out;
  logic       db_oe, int_n, rdy;

  always #2 clk = ~clk;

  adc_host_if u_adc_host_if (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .mode(mode),
    .chan_addr(chan_addr), .conv_start(conv_start), .conv_chan(conv_chan),
    .conv_done(conv_done), .conv_data(conv_data), .db_out(db_out),
    .db_oe(db_oe), .int_n(int_n), .rdy(rdy)
  );

  // Fixed-latency core model: result = {channel used, conversion index}.
  int         cnt;
  int         n_starts = 0;
  logic [0:0] core_chan;
  logic [6:0] core_idx;
  always @(posedge clk) begin
    if (rst) begin
      cnt <= 0; conv_done <= 1'b0; conv_data <= 8'h00; core_idx <= 7'd0; core_chan <= 1'b0;
    end else begin
      conv_done <= 1'b0;
      if (conv_start) begin
        n_starts  <= n_starts + 1;
        cnt       <= LAT;
        core_chan <= conv_chan;
        core_idx  <= core_idx + 7'd1;
      end else if (cnt == 1) begin
        cnt       <= 0;
        conv_done <= 1'b1;
        conv_data <= {core_chan, core_idx};
      end else if (cnt != 0) begin
        cnt <= cnt - 1;
      end
    end
  end

  int         n_chk = 0, n_fail = 0;
  bit         finished = 0;
  logic [6:0] exp_idx;
  logic       chan_hist;
  logic [7:0] exp_cur, want;
  int         s0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic m, input logic tied);
    @(negedge clk);
    rst = 1'b1; mode = m; cs_n = ~tied; rd_n = ~tied; wr_n = 1'b1; chan_addr = '0;
    tick(4);
    rst = 1'b0;
    tick(6);
    exp_idx = 7'd0; chan_hist = 1'b0; exp_cur = 8'h00;
  endtask

  // Expected data of a newly accepted conversion (channel lags by one start).
  task automatic note_start(input logic a);
    exp_idx   = exp_idx + 7'd1;
    exp_cur   = {chan_hist, exp_idx};
    chan_hist = a;
  endtask

  task automatic rd_full(input logic a);
    cs_n = 1'b0; rd_n = 1'b0; chan_addr = a; note_start(a);
    tick(30);
    chk("R11 channel from prior start", db_out, exp_cur);
    chk("R5 int low at end", int_n, 1'b0);
    rd_n = 1'b1; cs_n = 1'b1;
    tick(6);
  endtask

  initial begin
    do_reset(1'b0, 1'b0);
    chk("R12 conv_start", conv_start, 1'b0);
    chk("R12 int_n", int_n, 1'b1);
    chk("R12 rdy", rdy, 1'b1);
    chk("R12 db_oe", db_oe, 1'b0);
    chk("R12 db_out", db_out, 8'h00);

    // Read-start, read held through conversion
    cs_n = 1'b0; tick(4);
    chk("R6 rdy low after cs fall", rdy, 1'b0);
    s0 = n_starts;
    rd_n = 1'b0; chan_addr = 1'b1; note_start(1'b1);
    tick(2); chk("R1 no start before sync", conv_start, 1'b0);
    tick(1); chk("R1 start pulse", conv_start, 1'b1);
    tick(1); chk("R1 single pulse", conv_start, 1'b0);
    chk("R5 int high while converting", int_n, 1'b1);
    chk("R6 rdy low while busy", rdy, 1'b0);
    tick(26);
    chk("R4 new data with rd held", db_out, exp_cur);
    chk("R4 bus driven", db_oe, 1'b1);
    chk("R5 int low after done", int_n, 1'b0);
    chk("R6 rdy high after done", rdy, 1'b1);
    chk("R2 one start", n_starts - s0, 1);
    rd_n = 1'b1; tick(4);
    chk("R5 int high after rd rise", int_n, 1'b1);
    chk("R4 bus released", db_oe, 1'b0);
    cs_n = 1'b1; tick(4);

    // Read with chip select high
    s0 = n_starts;
    rd_n = 1'b0; tick(5);
    chk("R4 no drive with cs high", db_oe, 1'b0);
    rd_n = 1'b1; tick(30);
    chk("R2 cs high no start", n_starts - s0, 0);

    // Chip select alone
    cs_n = 1'b0; tick(4);
    chk("R6 rdy low on select", rdy, 1'b0);
    cs_n = 1'b1; tick(4);
    chk("R6 rdy high after idle deselect", rdy, 1'b1);

    // Channel sweep
    for (int i = 0; i < 8; i++) rd_full(((8'b10110010 >> i) & 8'd1) != 0);

    // Start during busy is ignored, address not captured
    s0 = n_starts;
    cs_n = 1'b0; rd_n = 1'b0; chan_addr = 1'b1; note_start(1'b1);
    tick(6); rd_n = 1'b1; tick(3);
    chan_addr = 1'b0; rd_n = 1'b0;
    tick(25);
    chk("R3 busy start ignored", n_starts - s0, 1);
    chk("R3 data of accepted conversion", db_out, exp_cur);
    rd_n = 1'b1; cs_n = 1'b1; tick(6);
    rd_full(1'b0);
    chk("R3 ignored address not captured", db_out[7], 1'b1);

    // Pipelined short reads
    do_reset(1'b0, 1'b0);
    for (int k = 0; k < 4; k++) begin
      logic a;
      a = (k != 1);
      if (k > 0) chk("R5 int low after background conversion", int_n, 1'b0);
      want = exp_cur;
      cs_n = 1'b0; rd_n = 1'b0; chan_addr = a; note_start(a);
      tick(4);
      chk("R7 pipelined read returns previous", db_out, want);
      chk("R7 bus driven", db_oe, 1'b1);
      chk("R5 int cleared by start", int_n, 1'b1);
      rd_n = 1'b1; cs_n = 1'b1;
      tick(40);
    end

    // Write-start
    do_reset(1'b1, 1'b0);
    cs_n = 1'b0; tick(3);
    s0 = n_starts;
    rd_n = 1'b0; tick(5); rd_n = 1'b1; tick(5);
    chk("R8 read alone no start", n_starts - s0, 0);
    wr_n = 1'b0; chan_addr = 1'b1; note_start(1'b1);
    tick(3); wr_n = 1'b1; tick(30);
    chk("R8 write starts", n_starts - s0, 1);
    chk("R8 int low at end", int_n, 1'b0);
    chk("R8 bus idle without read", db_oe, 1'b0);
    rd_n = 1'b0; tick(4);
    chk("R8 read returns result", db_out, exp_cur);
    rd_n = 1'b1; tick(4);
    chk("R5 int high after read", int_n, 1'b1);

    // Early read held
    want = exp_cur;
    wr_n = 1'b0; chan_addr = 1'b0; note_start(1'b0);
    tick(3); wr_n = 1'b1; tick(5);
    rd_n = 1'b0; tick(3);
    chk("R9 early read forces int", int_n, 1'b0);
    chk("R9 early read drives bus", db_oe, 1'b1);
    chk("R9 early read shows current data", db_out, want);
    tick(25);
    chk("R9 data after done", db_out, exp_cur);
    rd_n = 1'b1; tick(4);
    chk("R9 int high after rd rise", int_n, 1'b1);

    // Early read released before done
    wr_n = 1'b0; chan_addr = 1'b1; note_start(1'b1);
    tick(3); wr_n = 1'b1; tick(5);
    rd_n = 1'b0; tick(3);
    chk("R9 short early read forces int", int_n, 1'b0);
    rd_n = 1'b1; tick(4);
    chk("R9 int released", int_n, 1'b1);
    tick(25);
    chk("R9 no second interrupt", int_n, 1'b1);
    rd_n = 1'b0; tick(4);
    chk("R9 later read data", db_out, exp_cur);
    rd_n = 1'b1; cs_n = 1'b1; tick(4);

    // Reduced interface: select and read tied low
    do_reset(1'b1, 1'b1);
    for (int i = 0; i < 5; i++) begin
      logic a;
      a = (i % 2) != 0;
      wr_n = 1'b0; chan_addr = a; note_start(a);
      tick(3); wr_n = 1'b1; tick(30);
      chk("R10 bus follows result", db_out, exp_cur);
      chk("R10 bus driven", db_oe, 1'b1);
      chk("R10 int low", int_n, 1'b0);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule